// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Scheduler

The scheduler runs copy descriptors for up to eight independent DMA channels. Each descriptor gives a physical source address, a physical destination address and a length counted in 64-byte cache lines. A channel takes one descriptor at a time and finishes it before it takes the next one. Each descriptor is cut into chunks whose largest size is set by a shared size register. For every chunk the channel issues a read request at the source and then a write request at the destination, with the same size. The addresses go out exactly as given, with no translation.

All channels that have a request ready compete for one transaction request port. A round-robin arbiter grants one request per grant. A channel that has issued a request waits for a completion acknowledge tagged with its own channel number before it issues the next request. Because of this, several channels can each have a transaction outstanding at the same time. When the write of a descriptor's last chunk is acknowledged, the channel sets its bit in a sticky interrupt vector. Software clears a bit by writing 1 to it.

Top module: `xfer_sched`

## Requirements
- R1: A channel's `desc_ready` is high only while the channel is idle. A descriptor presented while the channel is busy is not taken and changes nothing.
- R2: The maximum chunk size in cache lines comes from `cfg_size`: 2'b00 gives 1 line (64 bytes), 2'b01 gives 2 lines, 2'b10 gives 4 lines, and 2'b11 gives 1 line. The size is sampled when each chunk's read is issued.
- R3: A chunk is the smaller of the maximum size and the lines still left, so the last chunk may be shorter. `req_lines` reports the chunk size in lines.
- R4: For each chunk the channel first issues a read (`req_write`=0) at the current source address, then a write (`req_write`=1) at the current destination address, with equal `req_lines`. Both addresses then advance by 64 bytes per line moved. The first chunk uses the descriptor's addresses unchanged.
- R5: A channel has at most one request outstanding. After a request is accepted, the channel issues nothing until `ack_valid` arrives with `ack_chan` equal to its number. An acknowledge for a channel with nothing outstanding is ignored.
- R6: Round-robin order: after channel k is granted, the next grant goes to the first requesting channel in the order k+1, k+2, … wrapping around. After reset the search starts at channel 0. `req_chan` names the granted channel.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and its channel, address, size and direction stay unchanged, even if other channels start requesting.
- R8: A channel's `irq` bit is set in the cycle after the acknowledge of its descriptor's final write. The bit stays set until a cycle with the matching `irq_clr` bit high. If a set and a clear happen in the same cycle, the set wins.
- R9: A zero-length descriptor is taken, issues no request, sets the channel's `irq` bit in the next cycle, and leaves the channel ready again.
- R10: After reset `req_valid` is 0, every `desc_ready` bit is 1 and `irq` is all zero.
- R11: Channels run in parallel: several channels may have a transaction outstanding at once, each waiting for its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Maximum chunk size code |
| desc_valid | input | NCH | Per-channel descriptor offered |
| desc_ready | output | NCH | Per-channel descriptor taken when high with valid |
| desc_src | input | NCH*AW | Per-channel source physical address |
| desc_dst | input | NCH*AW | Per-channel destination physical address |
| desc_len | input | NCH*LW | Per-channel length in cache lines |
| req_valid | output | 1 | Transaction request present |
| req_ready | input | 1 | Transaction request accepted |
| req_write | output | 1 | 0 = read at source, 1 = write at destination |
| req_chan | output | CW | Channel owning the request |
| req_addr | output | AW | Physical byte address of the request |
| req_lines | output | 3 | Request size in cache lines (1, 2 or 4, or fewer for the last chunk) |
| ack_valid | input | 1 | Completion acknowledge strobe |
| ack_chan | input | CW | Channel being acknowledged |
| irq | output | NCH | Sticky per-channel completion bits |
| irq_clr | input | NCH | Write-1-to-clear for `irq` |

## Verification
The assertions assume that the transaction side never acknowledges a request that was not accepted. They also assume that descriptor lengths fit the length field and that `cfg_size` does not change while a chunk is in flight. The stimulus only sends an acknowledge to a channel it saw accepted in an earlier cycle. The one exception is the deliberate stray acknowledge to an idle channel. The stimulus changes the size code only between descriptors and drives every input on the falling edge, so each accepted request and each acknowledge is a single clean cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int LINE_SHIFT = 6;
    localparam int LINES_W    = 3;

    typedef enum logic [2:0] {
        CH_IDLE = 3'd0,
        CH_RD   = 3'd1,
        CH_RDW  = 3'd2,
        CH_WR   = 3'd3,
        CH_WRW  = 3'd4
    } chan_st_e;

    function automatic logic [LINES_W-1:0] lines_for_size(input logic [1:0] code);
        case (code)
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/xfer_chan.sv
module xfer_chan
    import xfer_pkg::*;
#(
    parameter int AW = 40,
    parameter int LW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_size,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [AW-1:0]      desc_src,
    input  logic [AW-1:0]      desc_dst,
    input  logic [LW-1:0]      desc_len,
    output logic               want,
    output logic               want_write,
    output logic [AW-1:0]      want_addr,
    output logic [LINES_W-1:0] want_lines,
    input  logic               take,
    input  logic               ack,
    input  logic               irq_clr,
    output logic               irq
);

    typedef struct packed {
        chan_st_e           st;
        logic [AW-1:0]      src;
        logic [AW-1:0]      dst;
        logic [LW-1:0]      rem;
        logic [LINES_W-1:0] chunk;
        logic               irq;
    } ctx_t;

    ctx_t ctx_q, ctx_d;
    logic [LINES_W-1:0] max_lines;
    logic [LINES_W-1:0] chunk_c;
    logic               set_irq;

    always_comb begin
        max_lines = lines_for_size(cfg_size);
        chunk_c   = (ctx_q.rem < LW'(max_lines)) ? ctx_q.rem[LINES_W-1:0] : max_lines;
        ctx_d     = ctx_q;
        set_irq   = 1'b0;
        unique case (ctx_q.st)
            CH_IDLE: begin
                if (desc_valid) begin
                    if (desc_len == '0) begin
                        set_irq = 1'b1;
                    end else begin
                        ctx_d.src = desc_src;
                        ctx_d.dst = desc_dst;
                        ctx_d.rem = desc_len;
                        ctx_d.st  = CH_RD;
                    end
                end
            end
            CH_RD: begin
                if (take) begin
                    ctx_d.chunk = chunk_c;
                    ctx_d.st    = CH_RDW;
                end
            end
            CH_RDW: begin
                if (ack) ctx_d.st = CH_WR;
            end
            CH_WR: begin
                if (take) ctx_d.st = CH_WRW;
            end
            CH_WRW: begin
                if (ack) begin
                    ctx_d.src = ctx_q.src + (AW'(ctx_q.chunk) << LINE_SHIFT);
                    ctx_d.dst = ctx_q.dst + (AW'(ctx_q.chunk) << LINE_SHIFT);
                    ctx_d.rem = ctx_q.rem - LW'(ctx_q.chunk);
                    if (ctx_q.rem == LW'(ctx_q.chunk)) begin
                        ctx_d.st = CH_IDLE;
                        set_irq  = 1'b1;
                    end else begin
                        ctx_d.st = CH_RD;
                    end
                end
            end
            default: ctx_d.st = CH_IDLE;
        endcase
        ctx_d.irq = (ctx_q.irq & ~irq_clr) | set_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: CH_IDLE, src: '0, dst: '0, rem: '0, chunk: '0, irq: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign desc_ready = (ctx_q.st == CH_IDLE);
    assign want       = (ctx_q.st == CH_RD) || (ctx_q.st == CH_WR);
    assign want_write = (ctx_q.st == CH_WR);
    assign want_addr  = (ctx_q.st == CH_WR) ? ctx_q.dst : ctx_q.src;
    assign want_lines = (ctx_q.st == CH_RD) ? chunk_c : ctx_q.chunk;
    assign irq        = ctx_q.irq;

    // A busy channel always has lines left to move.
    assert_busy_has_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st != CH_IDLE) |-> (ctx_q.rem != '0));

    // The chunk size is never zero and never above four lines.
    assert_lines_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        want |-> (want_lines != '0 && want_lines <= 3'd4));

    // While waiting, only an acknowledge moves the channel on.
    assert_wait_for_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == CH_RDW && !ack) |=> (ctx_q.st == CH_RDW));

    // The interrupt rises only after a final acknowledge or a zero-length descriptor.
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctx_q.irq) |-> $past((ctx_q.st == CH_WRW && ack) ||
                                   (ctx_q.st == CH_IDLE && desc_valid)));

    // The bit is sticky until cleared.
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.irq && !irq_clr) |=> ctx_q.irq);

    // A zero-length descriptor leaves the channel idle with its interrupt set.
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == CH_IDLE && desc_valid && desc_len == '0) |=> (ctx_q.st == CH_IDLE && ctx_q.irq));

endmodule

// File: rtl/xfer_rr.sv
module xfer_rr #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 ready,
    output logic                 valid,
    output logic [$clog2(N)-1:0] gidx
);

    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] last;
        logic          hold;
        logic [IW-1:0] held;
    } arb_t;

    arb_t          arb_q, arb_d;
    logic [IW-1:0] pick;
    logic          found;
    int            idx;

    always_comb begin
        pick  = arb_q.last;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(arb_q.last) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
        valid = arb_q.hold | found;
        gidx  = arb_q.hold ? arb_q.held : pick;

        arb_d = arb_q;
        if (valid && ready) begin
            arb_d.last = gidx;
            arb_d.hold = 1'b0;
        end else if (valid) begin
            arb_d.hold = 1'b1;
            arb_d.held = gidx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '{last: IW'(N - 1), hold: 1'b0, held: '0};
        end else begin
            arb_q <= arb_d;
        end
    end

    // Only a requesting channel is granted.
    assert_grant_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[gidx]);

    // A stalled grant is kept until accepted.
    assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && gidx == $past(gidx)));

endmodule

// File: rtl/xfer_sched.sv
module xfer_sched
    import xfer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 40,
    parameter int LW  = 16,
    parameter int CW  = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_size,
    input  logic [NCH-1:0]     desc_valid,
    output logic [NCH-1:0]     desc_ready,
    input  logic [NCH*AW-1:0]  desc_src,
    input  logic [NCH*AW-1:0]  desc_dst,
    input  logic [NCH*LW-1:0]  desc_len,
    output logic               req_valid,
    input  logic               req_ready,
    output logic               req_write,
    output logic [CW-1:0]      req_chan,
    output logic [AW-1:0]      req_addr,
    output logic [LINES_W-1:0] req_lines,
    input  logic               ack_valid,
    input  logic [CW-1:0]      ack_chan,
    output logic [NCH-1:0]     irq,
    input  logic [NCH-1:0]     irq_clr
);

    logic [NCH-1:0]     want;
    logic [NCH-1:0]     want_write;
    logic [AW-1:0]      want_addr  [NCH];
    logic [LINES_W-1:0] want_lines [NCH];
    logic [NCH-1:0]     take;
    logic [CW-1:0]      gidx;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign take[i] = req_valid && req_ready && (gidx == CW'(i));

        xfer_chan #(.AW(AW), .LW(LW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_size   (cfg_size),
            .desc_valid (desc_valid[i]),
            .desc_ready (desc_ready[i]),
            .desc_src   (desc_src[i*AW +: AW]),
            .desc_dst   (desc_dst[i*AW +: AW]),
            .desc_len   (desc_len[i*LW +: LW]),
            .want       (want[i]),
            .want_write (want_write[i]),
            .want_addr  (want_addr[i]),
            .want_lines (want_lines[i]),
            .take       (take[i]),
            .ack        (ack_valid && (ack_chan == CW'(i))),
            .irq_clr    (irq_clr[i]),
            .irq        (irq[i])
        );
    end

    xfer_rr #(.N(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (want),
        .ready (req_ready),
        .valid (req_valid),
        .gidx  (gidx)
    );

    assign req_chan  = gidx;
    assign req_write = want_write[gidx];
    assign req_addr  = want_addr[gidx];
    assign req_lines = want_lines[gidx];

    // A stalled request keeps every field.
    assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_chan) && $stable(req_addr) &&
                                       $stable(req_lines) && $stable(req_write)));

    // An accepted channel stops requesting until it is acknowledged.
    assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !want[$past(gidx)]);

    // A channel that is taking a descriptor has no request out.
    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((desc_ready & want) == '0));

endmodule

// File: tb/sim_xfer_sched.sv
module sim_xfer_sched;

    localparam int NCH = 8;
    localparam int AW  = 40;
    localparam int LW  = 16;
    localparam int CW  = 3;

    typedef struct packed {
        logic [2:0]  ch;
        logic [1:0]  cfg;
        logic [7:0]  len;
        logic [39:0] src;
        logic [39:0] dst;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 2'b00, 8'd3,  40'h00_0000_1000, 40'h00_0000_8000},
        '{3'd5, 2'b01, 8'd5,  40'h80_0000_0040, 40'h00_1234_0000},
        '{3'd7, 2'b10, 8'd10, 40'h00_0002_0000, 40'h80_0003_0000},
        '{3'd2, 2'b11, 8'd2,  40'h00_0000_4000, 40'h00_0000_5000},
        '{3'd3, 2'b10, 8'd4,  40'h12_3456_7800, 40'h00_0000_0100},
        '{3'd1, 2'b10, 8'd3,  40'h00_00ff_ff00, 40'h7f_0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_size;
    logic [NCH-1:0]    desc_valid;
    logic [NCH-1:0]    desc_ready;
    logic [NCH*AW-1:0] desc_src;
    logic [NCH*AW-1:0] desc_dst;
    logic [NCH*LW-1:0] desc_len;
    logic              req_valid;
    logic              req_ready;
    logic              req_write;
    logic [CW-1:0]     req_chan;
    logic [AW-1:0]     req_addr;
    logic [2:0]        req_lines;
    logic              ack_valid;
    logic [CW-1:0]     ack_chan;
    logic [NCH-1:0]    irq;
    logic [NCH-1:0]    irq_clr;

    int errs   = 0;
    int checks = 0;
    int last_g = NCH - 1;
    int cyc    = 0;

    always #4 clk = ~clk;

    xfer_sched #(.NCH(NCH), .AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_chan(req_chan), .req_addr(req_addr), .req_lines(req_lines),
        .ack_valid(ack_valid), .ack_chan(ack_chan),
        .irq(irq), .irq_clr(irq_clr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int lines_for(input logic [1:0] code);
        if (code == 2'b01) return 2;
        if (code == 2'b10) return 4;
        return 1;
    endfunction

    function automatic int next_rr(input int last, input logic [NCH-1:0] mask);
        for (int k = 1; k <= NCH; k++) begin
            if (mask[(last + k) % NCH]) return (last + k) % NCH;
        end
        return -1;
    endfunction

    task automatic load(input int ch, input logic [AW-1:0] src, input logic [AW-1:0] dst,
                        input logic [LW-1:0] len);
        desc_src[ch*AW +: AW] = src;
        desc_dst[ch*AW +: AW] = dst;
        desc_len[ch*LW +: LW] = len;
        desc_valid[ch]        = 1'b1;
    endtask

    task automatic exp_req(input int ch, input bit wr, input logic [AW-1:0] addr,
                           input int lines, input string rq);
        chk(req_valid && req_chan == CW'(ch) && req_write == wr, rq,
            $sformatf("R4 request chan/dir (wr=%0d)", wr),
            {req_valid, 3'b0, req_write, 4'b0, 5'b0, req_chan}, {1'b1, 3'b0, wr, 4'b0, 5'b0, CW'(ch)});
        chk(req_addr == addr, "R4", $sformatf("address ch%0d wr=%0d", ch, wr), req_addr, addr);
        chk(req_lines == 3'(lines), rq, $sformatf("lines ch%0d wr=%0d", ch, wr), req_lines, lines);
    endtask

    task automatic run_desc(input vec_t v);
        int off;
        int ch;
        int mx;
        int n;
        ch = v.ch;
        mx = lines_for(v.cfg);
        @(negedge clk);
        cfg_size = v.cfg;
        load(ch, v.src, v.dst, LW'(v.len));
        @(negedge clk);
        desc_valid[ch] = 1'b0;
        off = 0;
        while (off < int'(v.len)) begin
            n = (int'(v.len) - off < mx) ? int'(v.len) - off : mx;
            exp_req(ch, 1'b0, v.src + AW'(off * 64), n, (n < mx) ? "R3" : "R2");
            last_g = ch;
            @(negedge clk);
            ack_valid = 1'b1;
            ack_chan  = CW'(ch);
            chk(!req_valid, "R5", "no request while read outstanding", req_valid, 0);
            chk(!desc_ready[ch], "R1", "busy channel not ready", desc_ready[ch], 0);
            @(negedge clk);
            ack_valid = 1'b0;
            exp_req(ch, 1'b1, v.dst + AW'(off * 64), n, (n < mx) ? "R3" : "R2");
            last_g = ch;
            @(negedge clk);
            ack_valid = 1'b1;
            @(negedge clk);
            ack_valid = 1'b0;
            off += n;
        end
        chk(irq[ch], "R8", $sformatf("irq after final ack ch%0d", ch), irq, 64'(1) << ch);
        chk(desc_ready[ch], "R1", "ready after completion", desc_ready[ch], 1);
        chk(!req_valid, "R4", "no extra request after descriptor", req_valid, 0);
        irq_clr[ch] = 1'b1;
        @(negedge clk);
        irq_clr[ch] = 1'b0;
        chk(irq == '0, "R8", "write-1-to-clear", irq, 0);
    endtask

    task automatic drain(input logic [NCH-1:0] mask, input logic [NCH-1:0] pend_in);
        logic [NCH-1:0] pend;
        logic [NCH-1:0] old;
        int n;
        pend = pend_in;
        n = 0;
        while (((irq & mask) != mask || pend != '0) && n < 500) begin
            @(negedge clk);
            n++;
            ack_valid = 1'b0;
            old = pend;
            for (int i = 0; i < NCH; i++) begin
                if (old[i] && !ack_valid) begin
                    ack_valid = 1'b1;
                    ack_chan  = CW'(i);
                    pend[i]   = 1'b0;
                end
            end
            if (req_valid) begin
                chk(!old[req_chan], "R5", "request from channel still outstanding", req_chan, 0);
                pend[req_chan] = 1'b1;
                last_g = int'(req_chan);
            end
            req_ready = 1'b1;
        end
        chk((irq & mask) == mask, "R8", "all drained channels flagged", irq, mask);
    endtask

    initial begin
        int e0, e1, e2;
        logic [AW-1:0] cap_addr;
        rst_n = 1'b0; cfg_size = 2'b00; desc_valid = '0; desc_src = '0; desc_dst = '0;
        desc_len = '0; req_ready = 1'b1; ack_valid = 1'b0; ack_chan = '0; irq_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!req_valid, "R10", "req_valid after reset", req_valid, 0);
        chk(desc_ready == '1, "R10", "desc_ready after reset", desc_ready, 8'hff);
        chk(irq == '0, "R10", "irq after reset", irq, 0);

        // Vector table: R2, R3, R4 over sizes and channels
        foreach (VECS[i]) run_desc(VECS[i]);

        // R9 zero length, with a same-cycle clear: R8 set wins
        @(negedge clk);
        load(4, 40'h1000, 40'h2000, '0);
        irq_clr[4] = 1'b1;
        @(negedge clk);
        desc_valid[4] = 1'b0;
        irq_clr[4]    = 1'b0;
        chk(irq[4], "R9", "zero length raises irq (set beats clear, R8)", irq, 8'h10);
        chk(!req_valid, "R9", "zero length issues nothing", req_valid, 0);
        chk(desc_ready[4], "R9", "zero length leaves channel ready", desc_ready[4], 1);
        repeat (3) @(negedge clk);
        chk(irq[4] && !req_valid, "R8", "irq sticky without clear", irq, 8'h10);
        irq_clr[4] = 1'b1;
        @(negedge clk);
        irq_clr[4] = 1'b0;
        chk(irq == '0, "R8", "clear after zero length", irq, 0);

        // R7 stall keeps the request while another channel joins
        cfg_size  = 2'b00;
        req_ready = 1'b0;
        load(6, 40'h00_0000_6000, 40'h00_0000_7000, LW'(1));
        @(negedge clk);
        desc_valid[6] = 1'b0;
        chk(req_valid && req_chan == 3'd6, "R6", "single requester granted", req_chan, 6);
        cap_addr = req_addr;
        load(0, 40'h00_0000_0800, 40'h00_0000_0900, LW'(1));
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            desc_valid[0] = 1'b0;
            chk(req_valid && req_chan == 3'd6 && req_addr == cap_addr && !req_write && req_lines == 3'd1,
                "R7", "stalled request unchanged", {req_chan, req_addr}, {3'd6, cap_addr});
        end
        drain(8'h41, 8'h00);
        irq_clr = 8'h41;
        @(negedge clk);
        irq_clr = '0;
        chk(irq == '0, "R8", "clear two bits at once", irq, 0);

        // R6 round robin among three, then R11 all outstanding together
        req_ready = 1'b0;
        load(1, 40'h100, 40'h900, LW'(1));
        load(3, 40'h300, 40'hb00, LW'(1));
        load(6, 40'h600, 40'he00, LW'(1));
        @(negedge clk);
        desc_valid = '0;
        e0 = next_rr(last_g, 8'h4a);
        e1 = next_rr(e0, 8'h4a & ~(8'h1 << e0));
        e2 = next_rr(e1, 8'h4a & ~(8'h1 << e0) & ~(8'h1 << e1));
        chk(req_valid && int'(req_chan) == e0, "R6", "first round-robin grant", req_chan, e0);
        req_ready = 1'b1;
        @(negedge clk);
        chk(req_valid && int'(req_chan) == e1, "R6", "second round-robin grant", req_chan, e1);
        @(negedge clk);
        chk(req_valid && int'(req_chan) == e2, "R6", "third round-robin grant", req_chan, e2);
        @(negedge clk);
        last_g = e2;
        chk(!req_valid && (desc_ready & 8'h4a) == '0, "R11", "three channels outstanding at once",
            {req_valid, desc_ready}, 0);
        drain(8'h4a, 8'h4a);
        irq_clr = 8'h4a;
        @(negedge clk);
        irq_clr = '0;

        // R5 stray acknowledge ignored; R1 descriptor on busy channel refused
        load(2, 40'h00_0000_a000, 40'h00_0000_b000, LW'(1));
        @(negedge clk);
        desc_valid[2] = 1'b0;
        exp_req(2, 1'b0, 40'h00_0000_a000, 1, "R2");
        last_g = 2;
        @(negedge clk);
        ack_valid = 1'b1;
        ack_chan  = 3'd5;
        load(2, 40'h00_0000_c000, 40'h00_0000_d000, LW'(3));
        @(negedge clk);
        chk(!desc_ready[2], "R1", "busy channel refuses descriptor", desc_ready[2], 0);
        ack_valid     = 1'b0;
        desc_valid[2] = 1'b0;
        chk(!req_valid, "R5", "stray ack does not release channel 2", req_valid, 0);
        chk(desc_ready[5] && !irq[5], "R5", "stray ack leaves channel 5 idle", {desc_ready[5], irq[5]}, 2);
        @(negedge clk);
        chk(!req_valid, "R5", "still waiting for own ack", req_valid, 0);
        drain(8'h04, 8'h04);
        @(negedge clk);
        chk(desc_ready[2] && !req_valid, "R1", "refused descriptor left no work", {desc_ready[2], req_valid}, 2);
        irq_clr = 8'h04;
        @(negedge clk);
        irq_clr = '0;
        chk(irq == '0, "R8", "final clear", irq, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule